// File: doc/BRIEF.md
# Word-Copy DMA Engine

This block moves a run of 32-bit words from one address to another on its own, so that a processor only has to program it and wait for an interrupt. Software sets the two address-stepping enables, the two local-address marks, the source address and the destination address through a small register port. It then writes a byte count, and that write starts the copy. Each word is read from the source over a request/acknowledge master port and then written to the destination. A source or destination whose stepping is disabled stays on one address, as a FIFO port does.

Three conditions end a run. Normal completion raises the done interrupt flag. An error response from the bus ends it with a bus-error status. If the bus gives no response for a programmable number of cycles, the run ends with a bus-timeout status. Both abnormal endings raise the error interrupt flag. The pending and enable registers share one bit layout, and the interrupt line is high whenever an enabled flag is pending.

Register word offsets on `cfg_addr`:

| Offset | Register |
|---|---|
| 0 | control: bit 31 steps the source, bit 30 steps the destination, bit 29 marks the source local, bit 28 marks the destination local |
| 1 | source address |
| 2 | destination address |
| 3 | byte count (a write starts the run) |
| 4 | status: bit 31 busy, bit 30 bus error, bit 29 bus timeout (read-only) |
| 5 | interrupt pending: bit 0 done, bit 1 error |
| 6 | interrupt enable: same bit layout as offset 5 |
| 7 | timeout limit, in cycles (0 turns the limit off) |

Top module: `wdma_engine`

## Requirements
- R1: After reset the status register (offset 4) reads 0, pending (offset 5) and enable (offset 6) read 0, the timeout limit (offset 7) reads 16, `irq` is low and `mem_req` is low.
- R2: A write to offset 3 while idle with a count of 4 or more sets busy (status bit 31) at the next edge. The first request is then a read at the source address with its two low bits forced to zero.
- R3: A count is rounded down to whole words, so floor(count/4) words move. A count below 4 moves no word and sets pending bit 0 at once.
- R4: Each word is read from the source and the same data is then written to the destination. A request keeps its address and direction until it gets an acknowledge or an error, and there is no request while the block is idle.
- R5: Control bit 31 set moves the source address up by 4 after each word, and clear holds it fixed. Control bit 30 does the same for the destination address.
- R6: `mem_local` equals control bit 29 during source reads and control bit 28 during destination writes.
- R7: After the write acknowledge of the last word, busy clears and pending bit 0 sets on the same edge.
- R8: An error response ends the run at once. No further request is made, status bit 30 sets and pending bit 1 sets, while pending bit 0 stays clear.
- R9: If a request gets no response for the number of consecutive cycles set in the timeout limit, the run ends. Status bit 29 sets and pending bit 1 sets.
- R10: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. `irq` is high exactly when some pending bit is set with its enable bit also set.
- R11: A write to offset 3 while busy is ignored: the current run finishes with its original word count.
- R12: Starting a new run clears status bits 30 and 29.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| cfg_we | input | 1 | register write strobe |
| cfg_addr | input | 3 | register word offset |
| cfg_wdata | input | 32 | register write data |
| cfg_rdata | output | 32 | register read data for `cfg_addr` (combinational) |
| mem_req | output | 1 | bus request, held until acknowledge or error |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_local | output | 1 | local-address mark for the current request |
| mem_addr | output | AW | bus word address (byte address, word aligned) |
| mem_wdata | output | 32 | write data |
| mem_rdata | input | 32 | read data, valid with `mem_ack` |
| mem_ack | input | 1 | successful response |
| mem_err | input | 1 | error response |
| irq | output | 1 | interrupt request |

## Verification
The bound checker watches a few rules on every cycle: no request while idle, a pending request held stable, a launch from idle starting with a source read, and an error response or timeout ending the run on the next edge with the matching status and pending flags. Only the bench's scenarios can show the data path. These scenarios cover the data landing at the right destination words for each stepping choice, the count rounding, the local marks, the pending and enable handshake on `irq`, a count write ignored while busy, and sticky status cleared by a new launch.

// File: rtl/wdma_pkg.sv
package wdma_pkg;

    typedef enum logic [1:0] {
        MV_IDLE = 2'd0,
        MV_RD   = 2'd1,
        MV_WR   = 2'd2
    } mv_state_t;

    localparam logic [2:0] OFS_CTRL  = 3'd0;
    localparam logic [2:0] OFS_SRC   = 3'd1;
    localparam logic [2:0] OFS_DST   = 3'd2;
    localparam logic [2:0] OFS_LEN   = 3'd3;
    localparam logic [2:0] OFS_STAT  = 3'd4;
    localparam logic [2:0] OFS_PEND  = 3'd5;
    localparam logic [2:0] OFS_EN    = 3'd6;
    localparam logic [2:0] OFS_LIMIT = 3'd7;

    localparam int unsigned N_IRQ   = 2;
    localparam int unsigned IRQ_DONE = 0;
    localparam int unsigned IRQ_FAIL = 1;

endpackage

// File: rtl/wdma_timer.sv
module wdma_timer #(
    parameter int unsigned TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             waiting,
    input  logic [TMO_W-1:0] limit,
    output logic             expire
);
    typedef struct packed {
        logic [TMO_W-1:0] cnt;
    } tm_t;

    tm_t tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (waiting) tm_d.cnt = tm_q.cnt + TMO_W'(1);
        else         tm_d.cnt = '0;
        expire = waiting && (limit != '0) && (tm_q.cnt >= limit - TMO_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end
endmodule

// File: rtl/wdma_irq.sv
module wdma_irq #(
    parameter int unsigned NI = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NI-1:0] set,
    input  logic          clr_we,
    input  logic          en_we,
    input  logic [NI-1:0] wdata,
    output logic [NI-1:0] pend,
    output logic [NI-1:0] en,
    output logic          irq
);
    typedef struct packed {
        logic [NI-1:0] pend;
        logic [NI-1:0] en;
    } ir_t;

    ir_t ir_d, ir_q;

    always_comb begin
        ir_d = ir_q;
        if (clr_we) ir_d.pend = ir_d.pend & ~wdata;
        ir_d.pend = ir_d.pend | set;
        if (en_we) ir_d.en = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ir_q <= '0;
        else        ir_q <= ir_d;
    end

    assign pend = ir_q.pend;
    assign en   = ir_q.en;
    assign irq  = |(ir_q.pend & ir_q.en);
endmodule

// File: rtl/wdma_mover.sv
module wdma_mover
    import wdma_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    input  logic [AW-1:0]    src,
    input  logic [AW-1:0]    dst,
    input  logic [3:0]       mode,
    input  logic             mem_ack,
    input  logic             mem_err,
    input  logic [31:0]      mem_rdata,
    input  logic             tmo,
    output logic             busy,
    output logic             mem_req,
    output logic             mem_we,
    output logic             mem_local,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    output logic             fin_ok,
    output logic             fin_berr,
    output logic             fin_tmo
);
    localparam int unsigned WC_W = LEN_W - 2;

    typedef struct packed {
        mv_state_t       st;
        logic [AW-1:0]   src;
        logic [AW-1:0]   dst;
        logic [WC_W-1:0] left;
        logic [31:0]     data;
        logic [3:0]      mode;
    } mv_t;

    mv_t mv_d, mv_q;
    logic [WC_W-1:0] words;

    assign words = len[LEN_W-1:2];

    always_comb begin
        mv_d     = mv_q;
        fin_ok   = 1'b0;
        fin_berr = 1'b0;
        fin_tmo  = 1'b0;
        unique case (mv_q.st)
            MV_IDLE: begin
                if (start) begin
                    if (words == '0) begin
                        fin_ok = 1'b1;
                    end else begin
                        mv_d.st   = MV_RD;
                        mv_d.src  = {src[AW-1:2], 2'b00};
                        mv_d.dst  = {dst[AW-1:2], 2'b00};
                        mv_d.left = words;
                        mv_d.mode = mode;
                    end
                end
            end
            MV_RD: begin
                if (mem_err) begin
                    fin_berr = 1'b1;
                    mv_d.st  = MV_IDLE;
                end else if (mem_ack) begin
                    mv_d.data = mem_rdata;
                    mv_d.st   = MV_WR;
                end else if (tmo) begin
                    fin_tmo = 1'b1;
                    mv_d.st = MV_IDLE;
                end
            end
            MV_WR: begin
                if (mem_err) begin
                    fin_berr = 1'b1;
                    mv_d.st  = MV_IDLE;
                end else if (mem_ack) begin
                    mv_d.left = mv_q.left - WC_W'(1);
                    if (mv_q.mode[3]) mv_d.src = mv_q.src + AW'(4);
                    if (mv_q.mode[2]) mv_d.dst = mv_q.dst + AW'(4);
                    if (mv_q.left == WC_W'(1)) begin
                        fin_ok  = 1'b1;
                        mv_d.st = MV_IDLE;
                    end else begin
                        mv_d.st = MV_RD;
                    end
                end else if (tmo) begin
                    fin_tmo = 1'b1;
                    mv_d.st = MV_IDLE;
                end
            end
            default: mv_d.st = MV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mv_q <= '{st: MV_IDLE, default: '0};
        else        mv_q <= mv_d;
    end

    assign busy      = (mv_q.st != MV_IDLE);
    assign mem_req   = busy;
    assign mem_we    = (mv_q.st == MV_WR);
    assign mem_addr  = mem_we ? mv_q.dst : mv_q.src;
    assign mem_wdata = mv_q.data;
    assign mem_local = mem_we ? mv_q.mode[0] : mv_q.mode[1];
endmodule

// File: rtl/wdma_engine.sv
module wdma_engine
    import wdma_pkg::*;
#(
    parameter int unsigned AW      = 32,
    parameter int unsigned LEN_W   = 16,
    parameter int unsigned TMO_W   = 8,
    parameter int unsigned TMO_RST = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [31:0]   cfg_wdata,
    output logic [31:0]   cfg_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_local,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_ack,
    input  logic          mem_err,
    output logic          irq
);
    typedef struct packed {
        logic [3:0]       ctrl;
        logic [AW-1:0]    src;
        logic [AW-1:0]    dst;
        logic [LEN_W-1:0] len;
        logic [TMO_W-1:0] limit;
        logic             st_berr;
        logic             st_tmo;
    } rg_t;

    rg_t rg_d, rg_q;

    logic             busy, start, tmo_expire;
    logic             fin_ok, fin_berr, fin_tmo;
    logic             stat_berr, stat_tmo;
    logic [N_IRQ-1:0] irq_pend, irq_en, irq_set;

    assign start = cfg_we && (cfg_addr == OFS_LEN) && !busy;

    always_comb begin
        rg_d = rg_q;
        if (cfg_we) begin
            unique case (cfg_addr)
                OFS_CTRL:  rg_d.ctrl  = cfg_wdata[31:28];
                OFS_SRC:   rg_d.src   = cfg_wdata[AW-1:0];
                OFS_DST:   rg_d.dst   = cfg_wdata[AW-1:0];
                OFS_LEN:   if (!busy) rg_d.len = cfg_wdata[LEN_W-1:0];
                OFS_LIMIT: rg_d.limit = cfg_wdata[TMO_W-1:0];
                default: ;
            endcase
        end
        if (start) begin
            rg_d.st_berr = 1'b0;
            rg_d.st_tmo  = 1'b0;
        end
        if (fin_berr) rg_d.st_berr = 1'b1;
        if (fin_tmo)  rg_d.st_tmo  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '{limit: TMO_W'(TMO_RST), default: '0};
        else        rg_q <= rg_d;
    end

    assign stat_berr = rg_q.st_berr;
    assign stat_tmo  = rg_q.st_tmo;

    always_comb begin
        unique case (cfg_addr)
            OFS_CTRL:  cfg_rdata = {rg_q.ctrl, 28'd0};
            OFS_SRC:   cfg_rdata = 32'(rg_q.src);
            OFS_DST:   cfg_rdata = 32'(rg_q.dst);
            OFS_LEN:   cfg_rdata = 32'(rg_q.len);
            OFS_STAT:  cfg_rdata = {busy, rg_q.st_berr, rg_q.st_tmo, 29'd0};
            OFS_PEND:  cfg_rdata = 32'(irq_pend);
            OFS_EN:    cfg_rdata = 32'(irq_en);
            default:   cfg_rdata = 32'(rg_q.limit);
        endcase
    end

    wdma_mover #(.AW(AW), .LEN_W(LEN_W)) u_mover (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .len      (cfg_wdata[LEN_W-1:0]),
        .src      (rg_q.src),
        .dst      (rg_q.dst),
        .mode     (rg_q.ctrl),
        .mem_ack  (mem_ack),
        .mem_err  (mem_err),
        .mem_rdata(mem_rdata),
        .tmo      (tmo_expire),
        .busy     (busy),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_local(mem_local),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .fin_ok   (fin_ok),
        .fin_berr (fin_berr),
        .fin_tmo  (fin_tmo)
    );

    wdma_timer #(.TMO_W(TMO_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .waiting(mem_req && !mem_ack && !mem_err),
        .limit  (rg_q.limit),
        .expire (tmo_expire)
    );

    assign irq_set[IRQ_DONE] = fin_ok;
    assign irq_set[IRQ_FAIL] = fin_berr | fin_tmo;

    wdma_irq #(.NI(N_IRQ)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (irq_set),
        .clr_we(cfg_we && (cfg_addr == OFS_PEND)),
        .en_we (cfg_we && (cfg_addr == OFS_EN)),
        .wdata (cfg_wdata[N_IRQ-1:0]),
        .pend  (irq_pend),
        .en    (irq_en),
        .irq   (irq)
    );
endmodule

// File: rtl/wdma_sva.sv
module wdma_sva #(
    parameter int unsigned AW    = 32,
    parameter int unsigned LEN_W = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic [2:0]    cfg_addr,
    input logic [31:0]   cfg_wdata,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ack,
    input logic          mem_err,
    input logic          busy,
    input logic          tmo_expire,
    input logic          stat_berr,
    input logic          stat_tmo,
    input logic [1:0]    irq_pend
);
    a_r2_launch_reads_first: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cfg_we && cfg_addr == 3'd3 && cfg_wdata[LEN_W-1:2] != '0)
        |=> (busy && mem_req && !mem_we));

    a_r4_idle_no_request: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    a_r4_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !mem_err && !tmo_expire)
        |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    a_r7_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !stat_berr && !stat_tmo) |-> irq_pend[0]);

    a_r8_error_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_err) |=> (!busy && stat_berr && irq_pend[1]));

    a_r9_timeout_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_expire |=> (!busy && stat_tmo && irq_pend[1]));
endmodule

bind wdma_engine wdma_sva #(.AW(AW), .LEN_W(LEN_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .mem_err   (mem_err),
    .busy      (busy),
    .tmo_expire(tmo_expire),
    .stat_berr (stat_berr),
    .stat_tmo  (stat_tmo),
    .irq_pend  (irq_pend)
);

// File: tb/test_wdma_engine.sv
module test_wdma_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = 3'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic [31:0] cfg_rdata;
    logic        mem_req, mem_we, mem_local;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = 32'd0;
    logic        mem_ack = 1'b0;
    logic        mem_err = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] mem [0:255];
    int          lat = 1;
    bit          stall = 0;
    bit          err_on = 0;
    logic [31:0] err_at = 32'd0;
    logic [3:0]  exp_ctrl = 4'd0;
    int          rd_cnt = 0, wr_cnt = 0, loc_bad = 0, wait_cnt = 0;

    always #10 clk = ~clk;

    wdma_engine i_wdma_engine (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_local(mem_local), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .mem_err(mem_err), .irq(irq)
    );

    // memory model: responses driven at negedge, consumed at posedge
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 0; mem_err = 0; wait_cnt = 0;
        end else if (mem_ack || mem_err) begin
            mem_ack = 0; mem_err = 0; wait_cnt = 0;
        end else if (mem_req) begin
            if (mem_local !== (mem_we ? exp_ctrl[0] : exp_ctrl[1])) loc_bad++;
            if (!stall) begin
                if (wait_cnt >= lat) begin
                    if (err_on && mem_addr == err_at) mem_err = 1;
                    else begin
                        mem_ack = 1;
                        if (mem_we) begin mem[mem_addr[9:2]] = mem_wdata; wr_cnt++; end
                        else begin mem_rdata = mem[mem_addr[9:2]]; rd_cnt++; end
                    end
                end else wait_cnt++;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_we = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); cfg_addr = a; #1 d = cfg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 3000; i++) begin
            rd(3'd4, s);
            if (!s[31]) break;
        end
    endtask

    task automatic setup(input logic [3:0] c, input logic [31:0] s, input logic [31:0] d);
        for (int i = 0; i < 256; i++) mem[i] = 32'hA500_0000 + i * 32'h0001_0003;
        rd_cnt = 0; wr_cnt = 0; loc_bad = 0;
        exp_ctrl = c;
        wr(3'd0, {c, 28'd0});
        wr(3'd1, s);
        wr(3'd2, d);
        wr(3'd5, 32'd3);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(3'd4, v); check("R1 status", v, 32'd0);
        rd(3'd5, v); check("R1 pending", v, 32'd0);
        rd(3'd6, v); check("R1 enable", v, 32'd0);
        rd(3'd7, v); check("R1 limit", v, 32'd16);
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 req", {31'd0, mem_req}, 32'd0);
    endtask

    task automatic t_basic();
        logic [31:0] v;
        int bad = 0;
        lat = 1;
        setup(4'hC, 32'h100, 32'h200);
        wr(3'd3, 32'd16);
        rd(3'd4, v); check("R2 busy after launch", {31'd0, v[31]}, 32'd1);
        wait_idle();
        for (int i = 0; i < 4; i++) if (mem[(32'h200 >> 2) + i] !== mem[(32'h100 >> 2) + i]) bad++;
        check("R4 copied data", bad, 0);
        check("R5 both stepping words", wr_cnt, 4);
        rd(3'd5, v); check("R7 done pending", v, 32'd1);
        rd(3'd4, v); check("R7 status idle", v, 32'd0);
    endtask

    task automatic t_round();
        logic [31:0] v, keep;
        lat = 0;
        setup(4'hC, 32'h102, 32'h300);
        keep = mem[(32'h308 >> 2)];
        wr(3'd3, 32'd10);
        wait_idle();
        check("R3 rounded count", wr_cnt, 2);
        check("R2 aligned src word0", mem[32'h300 >> 2], mem[32'h100 >> 2]);
        check("R2 aligned src word1", mem[32'h304 >> 2], mem[32'h104 >> 2]);
        check("R3 no third word", mem[32'h308 >> 2], keep);
        setup(4'hC, 32'h100, 32'h300);
        wr(3'd3, 32'd3);
        rd(3'd5, v); check("R3 short count done", v, 32'd1);
        check("R3 short count no bus", rd_cnt + wr_cnt, 0);
    endtask

    task automatic t_fixed();
        int bad = 0;
        logic [31:0] keep;
        lat = 2;
        setup(4'h4, 32'h040, 32'h280);
        wr(3'd3, 32'd12);
        wait_idle();
        for (int i = 0; i < 3; i++) if (mem[(32'h280 >> 2) + i] !== mem[32'h040 >> 2]) bad++;
        check("R5 fixed source", bad, 0);
        setup(4'h8, 32'h040, 32'h380);
        keep = mem[(32'h384 >> 2)];
        wr(3'd3, 32'd12);
        wait_idle();
        check("R5 fixed dest last word", mem[32'h380 >> 2], mem[(32'h040 >> 2) + 2]);
        check("R5 fixed dest neighbour", mem[32'h384 >> 2], keep);
    endtask

    task automatic t_local();
        lat = 1;
        setup(4'hE, 32'h100, 32'h200);
        wr(3'd3, 32'd8);
        wait_idle();
        check("R6 source local mark", loc_bad + (wr_cnt == 2 ? 0 : 100), 0);
        setup(4'hD, 32'h100, 32'h200);
        wr(3'd3, 32'd8);
        wait_idle();
        check("R6 dest local mark", loc_bad + (wr_cnt == 2 ? 0 : 100), 0);
    endtask

    task automatic t_err();
        logic [31:0] v;
        lat = 1;
        setup(4'hC, 32'h100, 32'h200);
        err_on = 1; err_at = 32'h108;
        wr(3'd3, 32'd16);
        wait_idle();
        err_on = 0;
        repeat (4) @(negedge clk);
        check("R8 words before error", wr_cnt, 2);
        check("R8 no more reads", rd_cnt, 2);
        rd(3'd4, v); check("R8 status", v, 32'h4000_0000);
        rd(3'd5, v); check("R8 pending", v, 32'd2);
    endtask

    task automatic t_timeout();
        logic [31:0] v;
        int cyc = 0;
        setup(4'hC, 32'h100, 32'h200);
        wr(3'd7, 32'd8);
        stall = 1;
        wr(3'd3, 32'd8);
        for (int i = 0; i < 100; i++) begin
            rd(3'd4, v);
            if (!v[31]) break;
            cyc++;
        end
        stall = 0;
        check("R9 run lasted the limit", (cyc >= 6 && cyc <= 9) ? 1 : 0, 1);
        rd(3'd4, v); check("R9 status (R12 cleared berr)", v, 32'h2000_0000);
        rd(3'd5, v); check("R9 pending", v, 32'd2);
        check("R9 no write", wr_cnt, 0);
        wr(3'd7, 32'd16);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        lat = 0;
        setup(4'hC, 32'h100, 32'h200);
        wr(3'd3, 32'd4);
        wait_idle();
        rd(3'd4, v); check("R12 status cleared", v, 32'd0);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        lat = 0;
        setup(4'hC, 32'h100, 32'h200);
        wr(3'd3, 32'd4);
        wait_idle();
        err_on = 1; err_at = 32'h100;
        wr(3'd3, 32'd4);
        wait_idle();
        err_on = 0;
        rd(3'd5, v); check("R10 both pending", v, 32'd3);
        check("R10 irq masked", {31'd0, irq}, 32'd0);
        wr(3'd6, 32'd1);
        check("R10 irq done enabled", {31'd0, irq}, 32'd1);
        wr(3'd5, 32'd2);
        rd(3'd5, v); check("R10 w1c single bit", v, 32'd1);
        wr(3'd5, 32'd1);
        rd(3'd5, v); check("R10 w1c done", v, 32'd0);
        check("R10 irq low", {31'd0, irq}, 32'd0);
        wr(3'd6, 32'd0);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        lat = 3;
        setup(4'hC, 32'h100, 32'h200);
        wr(3'd3, 32'd16);
        repeat (3) @(negedge clk);
        wr(3'd3, 32'd40);
        wait_idle();
        check("R11 count kept", wr_cnt, 4);
        rd(3'd3, v); check("R11 count register kept", v, 32'd16);
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_basic();
        t_round();
        t_fixed();
        t_local();
        t_err();
        t_timeout();
        t_clear();
        t_irq();
        t_busy_ignore();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule